// File: doc/BRIEF.md
# External Interrupt Request Controller

This block holds a vector of pending external interrupt requests next to an enable mask. From the two it drives one level-sensitive request line to a processor core. Any bus master, such as a system controller or a peer CPU, posts an interrupt by writing to a single 32-bit mapped word. The written value is an interrupt number, not a bit mask. The number is mapped to a pending bit in reversed order: number 0 lands on the most significant bit. A bus read of the same word returns the pending vector.

The core has two write paths. The first clears pending bits: every bit written as one is cleared. The second replaces the whole enable mask. A local alarm timer pulse posts a fixed interrupt number, exactly as a bus write of that number would. Bus accesses are only accepted at the full word size. Any other access size is dropped and reported with a one-cycle error flag.

Top module: `eirc_top`

## Requirements
- R1: A bus write with `bus_size` equal to 4 sets pending bit `(~bus_wdata) & (WIDTH-1)`. Only the low log2(WIDTH) data bits matter. With WIDTH=32, number 0 sets bit 31, number 31 sets bit 0, and number 37 sets bit 26. The bit is set at the clock edge that samples the write.
- R2: A bus write sets exactly one bit and leaves every other pending bit unchanged.
- R3: A bus read with `bus_size` equal to 4 loads the pending vector, as it stood before that edge, into `bus_rdata`. The value is visible from the following cycle and held until the next accepted read. Bits above WIDTH read as zero.
- R4: A core clear write clears every pending bit that is 1 in `core_clr_val` and leaves the bits written as 0 unchanged.
- R5: A core mask write replaces the entire mask with `core_mask_val`.
- R6: `irq_o` is registered and equals the OR-reduction of (pending AND mask). It changes at the same clock edge that updates pending or mask.
- R7: A pulse on `alarm_pulse` sets the pending bit of interrupt number ALARM_NUM (default 0, that is bit WIDTH-1), exactly like a bus write of that number.
- R8: When a set (from the bus or the alarm) and a core clear hit the same bit in one cycle, the bit ends up set.
- R9: A bus write or read whose `bus_size` is not 4 leaves the pending vector and `bus_rdata` unchanged. It raises `bus_err` for exactly the one cycle after the access. `bus_err` is low after any cycle with no such access.
- R10: Reset clears the pending vector, the mask, `irq_o`, `bus_err` and `bus_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe for the mapped word |
| bus_rd | input | 1 | Bus read strobe for the mapped word |
| bus_size | input | 3 | Access size in bytes; only 4 is legal |
| bus_wdata | input | 32 | Interrupt number to post |
| bus_rdata | output | 32 | Pending vector captured by the last legal read |
| bus_err | output | 1 | One-cycle pulse after an access of illegal size |
| alarm_pulse | input | 1 | Local timer pulse posting interrupt ALARM_NUM |
| core_clr_we | input | 1 | Core clear strobe |
| core_clr_val | input | WIDTH | Bits to clear (write one to clear) |
| core_mask_we | input | 1 | Core mask write strobe |
| core_mask_val | input | WIDTH | New mask value |
| irq_o | output | 1 | Level interrupt request to the core |

## Verification
Every result of this block is due one clock edge after the cycle that presents its stimulus. The new pending bit, the new mask, `irq_o`, `bus_err` and the captured `bus_rdata` all change at that edge. The driver pushes each expected value onto a scoreboard, stamped with the cycle number of that edge. The monitor samples one time unit after each rising edge and compares only the items due in that cycle. `irq_o` and `bus_err` are compared in every cycle. The pending vector is observed through legal bus reads, whose data is checked against the vector as it was before the read edge.

// File: rtl/eirc_pkg.sv
package eirc_pkg;
   localparam int       DATA_W     = 32;
   localparam logic [2:0] WORD_BYTES = 3'd4;

   function automatic logic size_ok(input logic [2:0] sz);
      return sz == WORD_BYTES;
   endfunction
endpackage

// File: rtl/eirc_set_decode.sv
module eirc_set_decode
   import eirc_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int ALARM_NUM = 0,
   parameter bit HAS_ALARM = 1,
   localparam int IDX_W    = $clog2(WIDTH)
) (
   input  logic             wr_ok,
   input  logic [IDX_W-1:0] wnum,
   input  logic             alarm,
   output logic [WIDTH-1:0] set_vec
);
   localparam logic [IDX_W-1:0] ALARM_IDX = ~IDX_W'(ALARM_NUM);

   logic [IDX_W-1:0] bus_idx;
   logic [WIDTH-1:0] bus_vec;
   logic [WIDTH-1:0] alarm_vec;

   // numbers map to bits in reversed order
   assign bus_idx = ~wnum;

   always_comb begin
      bus_vec = '0;
      if (wr_ok) bus_vec[bus_idx] = 1'b1;
   end

   generate
      if (HAS_ALARM) begin : g_alarm
         always_comb begin
            alarm_vec = '0;
            alarm_vec[ALARM_IDX] = alarm;
         end
      end else begin : g_no_alarm
         logic unused_alarm;
         assign unused_alarm = alarm;
         assign alarm_vec    = '0;
      end
   endgenerate

   assign set_vec = bus_vec | alarm_vec;
endmodule

// File: rtl/eirc_pending.sv
module eirc_pending #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_val,
   output logic [WIDTH-1:0] pend_q,
   output logic [WIDTH-1:0] pend_d
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         // set beats clear on the same bit
         assign pend_d[b] = set_vec[b] | (pend_q[b] & ~(clr_we & clr_val[b]));

         always_ff @(posedge clk) begin
            if (!rst_n) pend_q[b] <= 1'b0;
            else        pend_q[b] <= pend_d[b];
         end
      end
   endgenerate
endmodule

// File: rtl/eirc_mask_irq.sv
module eirc_mask_irq #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we,
   input  logic [WIDTH-1:0] mask_val,
   input  logic [WIDTH-1:0] pend_d,
   output logic [WIDTH-1:0] mask_q,
   output logic             irq_o
);
   logic [WIDTH-1:0] mask_d;

   assign mask_d = mask_we ? mask_val : mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         irq_o  <= 1'b0;
      end else begin
         mask_q <= mask_d;
         irq_o  <= |(pend_d & mask_d);
      end
   end
endmodule

// File: rtl/eirc_top.sv
module eirc_top
   import eirc_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int ALARM_NUM = 0,
   parameter bit HAS_ALARM = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic              alarm_pulse,
   input  logic              core_clr_we,
   input  logic [WIDTH-1:0]  core_clr_val,
   input  logic              core_mask_we,
   input  logic [WIDTH-1:0]  core_mask_val,
   output logic              irq_o
);
   localparam int IDX_W = $clog2(WIDTH);

   generate
      if (WIDTH < 2 || WIDTH > DATA_W || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("eirc_top: WIDTH must be a power of two from 2 to 32");
      end
      if (ALARM_NUM < 0 || ALARM_NUM >= WIDTH) begin : g_bad_alarm
         $error("eirc_top: ALARM_NUM out of range");
      end
   endgenerate

   logic             acc_ok;
   logic             wr_ok;
   logic             rd_ok;
   logic [WIDTH-1:0] set_vec;
   logic [WIDTH-1:0] pend_q;
   logic [WIDTH-1:0] pend_d;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] rd_q;
   logic             unused_wdata;

   assign acc_ok       = size_ok(bus_size);
   assign wr_ok        = bus_wr & acc_ok;
   assign rd_ok        = bus_rd & acc_ok;
   assign unused_wdata = ^bus_wdata[DATA_W-1:IDX_W];

   eirc_set_decode #(
      .WIDTH(WIDTH), .ALARM_NUM(ALARM_NUM), .HAS_ALARM(HAS_ALARM)
   ) u_dec (
      .wr_ok  (wr_ok),
      .wnum   (bus_wdata[IDX_W-1:0]),
      .alarm  (alarm_pulse),
      .set_vec(set_vec)
   );

   eirc_pending #(.WIDTH(WIDTH)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_we (core_clr_we),
      .clr_val(core_clr_val),
      .pend_q (pend_q),
      .pend_d (pend_d)
   );

   eirc_mask_irq #(.WIDTH(WIDTH)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (core_mask_we),
      .mask_val(core_mask_val),
      .pend_d  (pend_d),
      .mask_q  (mask_q),
      .irq_o   (irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q    <= '0;
         bus_err <= 1'b0;
      end else begin
         if (rd_ok) rd_q <= pend_q;
         bus_err <= (bus_wr | bus_rd) & ~acc_ok;
      end
   end

   generate
      if (WIDTH == DATA_W) begin : g_rd_full
         assign bus_rdata = rd_q;
      end else begin : g_rd_ext
         assign bus_rdata = {{(DATA_W - WIDTH){1'b0}}, rd_q};
      end
   endgenerate
endmodule

// File: rtl/eirc_chk.sv
module eirc_chk #(
   parameter int WIDTH     = 32,
   parameter int ALARM_NUM = 0,
   localparam int IDX_W    = $clog2(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [2:0]       bus_size,
   input logic [IDX_W-1:0] wnum,
   input logic [WIDTH-1:0] rdata,
   input logic             bus_err,
   input logic             alarm_pulse,
   input logic             core_clr_we,
   input logic [WIDTH-1:0] core_clr_val,
   input logic             core_mask_we,
   input logic [WIDTH-1:0] core_mask_val,
   input logic             irq_o,
   input logic [WIDTH-1:0] pend_q,
   input logic [WIDTH-1:0] mask_q
);
   localparam int ALARM_BIT = WIDTH - 1 - ALARM_NUM;

   logic [IDX_W-1:0] exp_idx;
   logic             good;
   logic             bad;
   assign exp_idx = ~wnum;
   assign good    = bus_size == 3'd4;
   assign bad     = (bus_wr | bus_rd) & ~good;

   // R1 and R8: a legal write always leaves its bit set
   a_r1_bus_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && good |=> pend_q[$past(exp_idx)]);

   // R7
   a_r7_alarm_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |=> pend_q[ALARM_BIT]);

   // R4
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      core_clr_we && !bus_wr && !alarm_pulse |=> (pend_q & $past(core_clr_val)) == '0);

   // R5
   a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      core_mask_we |=> mask_q == $past(core_mask_val));

   // R6
   a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|(pend_q & mask_q)));

   // R3
   a_r3_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && good |=> rdata == $past(pend_q));

   // R9
   a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> bus_err);
   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bad |=> !bus_err);
   a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !good && !alarm_pulse && !core_clr_we |=> pend_q == $past(pend_q));
endmodule

bind eirc_top eirc_chk #(.WIDTH(WIDTH), .ALARM_NUM(ALARM_NUM)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_size     (bus_size),
   .wnum         (bus_wdata[$clog2(WIDTH)-1:0]),
   .rdata        (bus_rdata[WIDTH-1:0]),
   .bus_err      (bus_err),
   .alarm_pulse  (alarm_pulse),
   .core_clr_we  (core_clr_we),
   .core_clr_val (core_clr_val),
   .core_mask_we (core_mask_we),
   .core_mask_val(core_mask_val),
   .irq_o        (irq_o),
   .pend_q       (pend_q),
   .mask_q       (mask_q)
);

// File: tb/eirc_top_tb.sv
module eirc_top_tb;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, alarm_pulse = 1'b0;
   logic [2:0]    bus_size = 3'd4;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err, irq_o;
   logic          core_clr_we = 1'b0, core_mask_we = 1'b0;
   logic [W-1:0]  core_clr_val = '0, core_mask_val = '0;

   int checks = 0, errors = 0, cyc = 0;
   logic [W-1:0] m_pend = '0, m_mask = '0;
   logic [31:0]  m_rd = '0;

   typedef struct {
      int          due;
      int          kind;   // 0 irq, 1 rdata, 2 err
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb_q[$];

   eirc_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .alarm_pulse(alarm_pulse), .core_clr_we(core_clr_we),
      .core_clr_val(core_clr_val), .core_mask_we(core_mask_we),
      .core_mask_val(core_mask_val), .irq_o(irq_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: compare items due in this cycle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            case (it.kind)
               0:       check(it.req, {31'd0, irq_o}, it.exp);
               1:       check(it.req, bus_rdata, it.exp);
               default: check(it.req, {31'd0, bus_err}, it.exp);
            endcase
         end
      end
   end

   // driver: one cycle of stimulus plus model prediction
   task automatic step(input logic wr, input logic rd, input logic [2:0] sz,
                       input logic [31:0] num, input logic alm,
                       input logic cwe, input logic [W-1:0] cval,
                       input logic mwe, input logic [W-1:0] mval,
                       input string req);
      logic [W-1:0] setv;
      logic ok;
      item_t it;
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_size = sz; bus_wdata = num;
      alarm_pulse = alm; core_clr_we = cwe; core_clr_val = cval;
      core_mask_we = mwe; core_mask_val = mval;
      ok = (sz == 3'd4);
      setv = '0;
      if (wr && ok) setv[31 - (num % 32)] = 1'b1;   // R1 reversed numbering
      if (alm) setv[31] = 1'b1;                     // R7 number 0
      if (rd && ok) m_rd = m_pend;                  // R3 old value
      m_pend = (m_pend & ~(cwe ? cval : '0)) | setv; // R4, R8
      if (mwe) m_mask = mval;                       // R5
      it.due = cyc + 1;
      it.kind = 0; it.exp = {31'd0, |(m_pend & m_mask)}; it.req = {"R6 ", req};
      sb_q.push_back(it);
      it.kind = 2; it.exp = {31'd0, (wr | rd) & ~ok}; it.req = {"R9 ", req};
      sb_q.push_back(it);
      it.kind = 1; it.exp = m_rd; it.req = {"R3 ", req};
      sb_q.push_back(it);
      @(posedge clk);
   endtask

   task automatic idle(input string req);
      step(0, 0, 3'd4, 0, 0, 0, '0, 0, '0, req);
   endtask
   task automatic wr_num(input logic [31:0] n, input string req);
      step(1, 0, 3'd4, n, 0, 0, '0, 0, '0, req);
   endtask
   task automatic rd_chk(input string req);
      step(0, 1, 3'd4, 0, 0, 0, '0, 0, '0, req);
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      check("R10 irq", {31'd0, irq_o}, 0);
      check("R10 err", {31'd0, bus_err}, 0);
      check("R10 rdata", bus_rdata, 0);
      rd_chk("R10 pending zero");
      idle("R10 after read");
      // R1: number 0 -> bit 31, raises irq once masked in
      step(0, 0, 3'd4, 0, 0, 0, '0, 1, '1, "R5 mask all");
      wr_num(0, "R1 num0");
      rd_chk("R1 num0 read");
      wr_num(31, "R1 num31");
      wr_num(37, "R1 R2 num37 upper bits ignored");
      rd_chk("R2 three bits");
      idle("R2 capture");
      // R4 clear
      step(0, 0, 3'd4, 0, 0, 1, 32'h8000_0000, 0, '0, "R4 clear msb");
      step(0, 0, 3'd4, 0, 0, 1, 32'h0000_0000, 0, '0, "R4 clear zero");
      rd_chk("R4 read");
      idle("R4 capture");
      // R5 / R6 mask effects
      step(0, 0, 3'd4, 0, 0, 0, '0, 1, 32'h0, "R5 mask none");
      step(0, 0, 3'd4, 0, 0, 0, '0, 1, 32'h1, "R5 mask bit0");
      step(0, 0, 3'd4, 0, 0, 1, 32'h1, 0, '0, "R6 clear masked-in bit");
      // R7 alarm
      step(0, 0, 3'd4, 0, 1, 0, '0, 1, 32'h8000_0000, "R7 alarm");
      rd_chk("R7 read");
      idle("R7 capture");
      // R8 set wins over clear
      step(1, 0, 3'd4, 3, 0, 1, '1, 0, '0, "R8 set+clear");
      step(0, 0, 3'd4, 0, 1, 1, '1, 0, '0, "R8 alarm+clear");
      rd_chk("R8 read");
      idle("R8 capture");
      // R9 bad sizes
      step(1, 0, 3'd2, 1, 0, 0, '0, 0, '0, "R9 bad write");
      idle("R9 err drops");
      step(0, 1, 3'd1, 0, 0, 0, '0, 0, '0, "R9 bad read rdata held");
      rd_chk("R9 pending unchanged");
      idle("R9 capture");
      wr_num(31, "R1 num31 again");
      rd_chk("R1 final read");
      idle("final");
      idle("final2");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule